// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the data-memory address for a load or store. A request carries a 3-bit mode, two 32-bit register operands (base and index), a 16-bit signed displacement and a 3-bit scale shift. The block returns a registered effective address. In the post-increment mode it also returns an updated base value for the register file to write back. In the pointer-chasing mode it first reads memory at the base address and uses the returned word as the address.

Requests are taken when `req_valid` and `req_ready` are both high. A direct-mode result appears one cycle after acceptance. The pointer mode holds `req_ready` low until its memory read has returned.

The sequencer has three states:
- `ST_IDLE` accepts requests.
- `ST_FETCH` drives a one-cycle memory read.
- `ST_WAIT` waits for read data.

Its transitions are:
- `ST_IDLE` → `ST_FETCH` when a pointer-mode request is accepted.
- `ST_FETCH` → `ST_WAIT` always.
- `ST_WAIT` → `ST_IDLE` when `mem_rd_valid` is seen.
- Every other case holds the current state.

Top module: `addr_gen`

## Requirements
- R1: After reset, `res_valid`, `wb_valid`, `err_illegal` and `mem_rd_en` are low and `req_ready` is high.
- R2: Mode 0 (register indirect) gives an address equal to `req_base`.
- R3: Mode 1 (displacement) gives `req_base` plus `req_disp` sign-extended to 32 bits, wrapping modulo 2^32.
- R4: Mode 2 (index plus base) gives `req_base + req_index`, wrapping modulo 2^32.
- R5: Mode 5 (scaled) gives `req_base + (req_index << s) + sext(req_disp)`. Here s equals `req_shift` for values 0 to 5, and shift codes 6 and 7 are treated as 5. All arithmetic wraps.
- R6: Mode 4 (post-increment) gives an address equal to `req_base`. In the same cycle it raises `wb_valid` with `wb_data = req_base + 4`. No other mode raises `wb_valid`.
- R7: Mode 3 (memory indirect) raises `mem_rd_en` for exactly one cycle, one cycle after acceptance, with `mem_rd_addr = req_base`. `res_valid` rises one cycle after the cycle in which `mem_rd_valid` is high, and `res_addr` then equals that cycle's `mem_rd_data`.
- R8: While a pointer read is outstanding, `req_ready` is low. Requests presented in that time are ignored and produce no result.
- R9: Mode codes 6 and 7 raise `err_illegal` for one cycle, one cycle after acceptance, with `res_valid` and `wb_valid` low.
- R10: For modes 0, 1, 2, 4 and 5, `res_valid` is high for exactly one cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 3 | Addressing mode code |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_disp | input | 16 | Signed displacement |
| req_shift | input | 3 | Scale as a left-shift amount |
| mem_rd_en | output | 1 | Pointer read strobe |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_rd_valid | input | 1 | Pointer read data valid |
| mem_rd_data | input | 32 | Pointer read data |
| res_valid | output | 1 | Effective address valid |
| res_addr | output | 32 | Effective address |
| wb_valid | output | 1 | Base write-back valid |
| wb_data | output | 32 | Updated base value |
| err_illegal | output | 1 | Illegal mode flag |

## Verification
Direct-mode and illegal-mode results are registered at the acceptance edge. The bench therefore samples one time unit after that edge, and samples once more after the following edge to confirm that the pulse has ended. For the pointer mode, the bench first checks the read strobe just after the acceptance edge. It then returns data after one to three cycles, while stray requests are held on the input. The address is checked just after the edge that sampled `mem_rd_valid`, and one further cycle confirms that no stray request produced a result.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
    typedef enum logic [2:0] {
        M_REG_IND   = 3'd0,
        M_DISP      = 3'd1,
        M_IDX_BASE  = 3'd2,
        M_MEM_IND   = 3'd3,
        M_POST_INC  = 3'd4,
        M_SCALED    = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ag_ea_calc.sv
module ag_ea_calc
    import addr_gen_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 16,
    parameter int SHW       = 3,
    parameter int MAX_SHIFT = 5,
    parameter int STEP      = 4
) (
    input  logic [2:0]     mode,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  index,
    input  logic [DW-1:0]  disp,
    input  logic [SHW-1:0] shift,
    output logic [AW-1:0]  ea,
    output logic [AW-1:0]  wb_val,
    output logic           legal,
    output logic           indirect,
    output logic           post_inc
);
    localparam logic [SHW-1:0] MAX_SH  = SHW'(MAX_SHIFT);
    localparam logic [AW-1:0]  STEP_AW = AW'(STEP);

    logic [SHW-1:0] sh_eff;
    logic [AW-1:0]  disp_x;
    logic [AW-1:0]  stage [0:SHW];

    assign sh_eff   = (shift > MAX_SH) ? MAX_SH : shift;
    assign disp_x   = {{(AW-DW){disp[DW-1]}}, disp};
    assign stage[0] = index;

    // logarithmic shifter, one stage per shift bit
    genvar g;
    generate
        for (g = 0; g < SHW; g++) begin : g_shift
            assign stage[g+1] = sh_eff[g] ? (stage[g] << (1 << g)) : stage[g];
        end
    endgenerate

    always_comb begin
        ea       = base;
        legal    = 1'b1;
        indirect = 1'b0;
        post_inc = 1'b0;
        unique case (mode)
            M_REG_IND:  ea = base;
            M_DISP:     ea = base + disp_x;
            M_IDX_BASE: ea = base + index;
            M_MEM_IND:  begin ea = base; indirect = 1'b1; end
            M_POST_INC: begin ea = base; post_inc = 1'b1; end
            M_SCALED:   ea = base + stage[SHW] + disp_x;
            default:    legal = 1'b0;
        endcase
    end

    assign wb_val = base + STEP_AW;
endmodule

// File: rtl/ag_seq.sv
module ag_seq
    import addr_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          indirect,
    input  logic [AW-1:0] base,
    input  logic          mem_rd_valid,
    output logic          ready,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    output logic          ptr_done
);
    seq_state_e    state, state_nx;
    logic [AW-1:0] ptr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            state <= state_nx;
            if (accept && indirect) ptr_q <= base;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        ready     = 1'b0;
        mem_rd_en = 1'b0;
        ptr_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready = 1'b1;
                if (accept && indirect) state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                state_nx  = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    ptr_done = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign mem_rd_addr = ptr_q;

    AST_READ_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && indirect) |=> (mem_rd_en && mem_rd_addr == $past(base))); // R7
    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || ptr_done) |-> !ready); // R8
endmodule

// File: rtl/addr_gen.sv
module addr_gen
    import addr_gen_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 16,
    parameter int SHW       = 3,
    parameter int MAX_SHIFT = 5,
    parameter int STEP      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [2:0]     req_mode,
    input  logic [AW-1:0]  req_base,
    input  logic [AW-1:0]  req_index,
    input  logic [DW-1:0]  req_disp,
    input  logic [SHW-1:0] req_shift,
    output logic           mem_rd_en,
    output logic [AW-1:0]  mem_rd_addr,
    input  logic           mem_rd_valid,
    input  logic [AW-1:0]  mem_rd_data,
    output logic           res_valid,
    output logic [AW-1:0]  res_addr,
    output logic           wb_valid,
    output logic [AW-1:0]  wb_data,
    output logic           err_illegal
);
    logic [AW-1:0] ea, wb_val;
    logic          legal, indirect, post_inc;
    logic          accept, ptr_done;

    ag_ea_calc #(.AW(AW), .DW(DW), .SHW(SHW), .MAX_SHIFT(MAX_SHIFT), .STEP(STEP)) u_calc (
        .mode(req_mode), .base(req_base), .index(req_index), .disp(req_disp),
        .shift(req_shift), .ea(ea), .wb_val(wb_val), .legal(legal),
        .indirect(indirect), .post_inc(post_inc)
    );

    assign accept = req_valid && req_ready;

    ag_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .indirect(indirect && legal),
        .base(req_base), .mem_rd_valid(mem_rd_valid), .ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .ptr_done(ptr_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_addr    <= '0;
            wb_valid    <= 1'b0;
            wb_data     <= '0;
            err_illegal <= 1'b0;
        end else begin
            res_valid   <= ptr_done || (accept && legal && !indirect);
            wb_valid    <= accept && post_inc;
            err_illegal <= accept && !legal;
            if (ptr_done)    res_addr <= mem_rd_data;
            else if (accept) res_addr <= ea;
            if (accept && post_inc) wb_data <= wb_val;
        end
    end

    AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && legal && !indirect) |=> res_valid); // R10
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> (!res_valid && !wb_valid)); // R9
    AST_WB_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (res_valid && wb_data == res_addr + AW'(STEP))); // R6
    AST_PTR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_done |=> (res_valid && res_addr == $past(mem_rd_data))); // R7
endmodule

// File: tb/tb_addr_gen.sv
module tb_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_mode = '0;
    logic [31:0] req_base = '0, req_index = '0;
    logic [15:0] req_disp = '0;
    logic [2:0]  req_shift = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        res_valid, wb_valid, err_illegal;
    logic [31:0] res_addr, wb_data;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
        .req_disp(req_disp), .req_shift(req_shift), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .res_valid(res_valid), .res_addr(res_addr),
        .wb_valid(wb_valid), .wb_data(wb_data), .err_illegal(err_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] d);
        return {{16{d[15]}}, d};
    endfunction

    function automatic logic [31:0] model(input logic [2:0] m, input logic [31:0] b,
                                          input logic [31:0] x, input logic [15:0] d,
                                          input logic [2:0] s);
        int unsigned sa;
        sa = (s > 3'd5) ? 5 : int'(s);
        case (m)
            3'd1:    return b + sx(d);
            3'd2:    return b + x;
            3'd5:    return b + (x * (32'd1 << sa)) + sx(d);
            default: return b;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd4: return "R6";
            3'd5: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic direct(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                          input logic [15:0] d, input logic [2:0] s);
        logic legal;
        legal = (m != 3'd3) && (m < 3'd6);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_base = b; req_index = x;
        req_disp = d; req_shift = s;
        @(posedge clk); #1;
        if (legal) begin
            chk({tag(m), "/R10 res_valid"}, 32'(res_valid), 32'd1);
            chk({tag(m), " res_addr"}, res_addr, model(m, b, x, d, s));
            chk("R6 wb_valid", 32'(wb_valid), 32'(m == 3'd4));
            if (m == 3'd4) chk("R6 wb_data", wb_data, b + 32'd4);
            chk("R9 err low", 32'(err_illegal), 32'd0);
        end else begin
            chk("R9 err_illegal", 32'(err_illegal), 32'd1);
            chk("R9 res_valid low", 32'(res_valid), 32'd0);
            chk("R9 wb_valid low", 32'(wb_valid), 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R10 single pulse", 32'(res_valid | err_illegal | wb_valid), 32'd0);
    endtask

    task automatic indirect(input logic [31:0] b, input int lat);
        logic [31:0] ptr;
        ptr = b * 32'd3 + 32'h1357_9bdf;
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'd3; req_base = b;
        @(posedge clk); #1;
        chk("R7 rd_en", 32'(mem_rd_en), 32'd1);
        chk("R7 rd_addr", mem_rd_addr, b);
        chk("R8 ready low", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_mode = 3'd2; req_base = 32'hdead_0000; // stray request, must be ignored
        @(posedge clk); #1;
        chk("R7 rd_en one cycle", 32'(mem_rd_en), 32'd0);
        for (int i = 1; i < lat; i++) begin
            @(posedge clk); #1;
            chk("R8 no result while busy", 32'(res_valid), 32'd0);
            chk("R8 ready low", 32'(req_ready), 32'd0);
        end
        @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = ptr;
        @(posedge clk); #1;
        chk("R7 res_valid", 32'(res_valid), 32'd1);
        chk("R7 res_addr", res_addr, ptr);
        chk("R6 wb_valid low", 32'(wb_valid), 32'd0);
        @(negedge clk);
        mem_rd_valid = 1'b0; req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R8 stray ignored", 32'(res_valid), 32'd0);
        chk("R8 ready back", 32'(req_ready), 32'd1);
    endtask

    initial begin
        logic [31:0] bases [6];
        logic [15:0] disps [5];
        bases = '{32'h0, 32'h1, 32'h7fff_fffc, 32'hffff_fffe, 32'h8000_0000, 32'h1234_5678};
        disps = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        chk("R1 err", 32'(err_illegal), 32'd0);
        chk("R1 rd_en", 32'(mem_rd_en), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 ready", 32'(req_ready), 32'd1);
        for (int bi = 0; bi < 6; bi++) begin
            for (int di = 0; di < 5; di++) begin
                logic [31:0] ix;
                ix = bases[(bi + di) % 6] ^ 32'h0f0f_00f1;
                direct(3'd0, bases[bi], ix, disps[di], 3'd0);
                direct(3'd1, bases[bi], ix, disps[di], 3'd0);
                direct(3'd2, bases[bi], ix, disps[di], 3'd0);
                direct(3'd4, bases[bi], ix, disps[di], 3'd0);
                for (int s = 0; s < 8; s++)
                    direct(3'd5, bases[bi], ix, disps[di], 3'(s));
            end
            direct(3'd6, bases[bi], 32'h5, 16'h2, 3'd1);
            direct(3'd7, bases[bi], 32'h5, 16'h2, 3'd1);
            indirect(bases[bi], (bi % 3) + 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule